// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block is a binary-coded-decimal clock and calendar. It runs on a 32.768 kHz reference clock and divides it down with a binary prescaler to produce a once-per-second tick. On each tick the seconds field advances, and a carry ripples upward through minutes, hours, day of month, weekday, month and a two-digit year. The prescaler also brings out three divided clocks, at nominally 4096 Hz, 64 Hz and 1 Hz, for neighbouring logic.

A host loads and reads every field through a simple register port. The write port is synchronous and the read port is combinational. Hours can be counted in a 24-hour encoding or in a 12-hour encoding that carries an afternoon flag. A stop input freezes every field and holds the prescaler at zero. Releasing stop therefore makes the next second begin at a known phase of the reference clock.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: The prescaler is `PRE_W` bits wide and counts reference cycles while stop is low. `tick_1hz_o` is high for one cycle in every 2^PRE_W cycles, in the cycle where the count is all ones. The divided outputs are count bits 2, 8 and PRE_W-1, each clamped to PRE_W-1.
- R2: While `stop_i` is high, the prescaler is held at zero, the tick and all divided outputs are low, and no field changes except by a write. After stop is released, seconds advance on the 2^PRE_W-th rising edge at which stop is sampled low, and not before.
- R3: Seconds and minutes count 00 to 59 in BCD. On a wrap to 00 they carry into the next field.
- R4: With `mode_12h_i` low, hours count 00 to 23 in BCD. The step from 23 to 00 carries into the day.
- R5: With `mode_12h_i` high, hour bit 5 is the afternoon flag and bits 4:0 hold BCD 01 to 12. The step 11 to 12 toggles the flag, the step 12 to 01 keeps it, and only the step from 11 with the flag set carries into the day.
- R6: The day of month runs from 01 to the month length: 30 for months 04, 06, 09 and 11, 31 for the other months except 02, and 28 for month 02, or 29 when the BCD year's value is divisible by 4. A wrap returns the day to 01 and carries into the month.
- R7: The weekday is a 3-bit code, 0 for Sunday through 6 for Saturday. It advances with every day carry, and any code of 6 or more steps to 0.
- R8: Months run 01 to 12 and carry into the year when they wrap to 01. Years run 00 to 99 and wrap to 00.
- R9: Field addresses are 0 seconds, 1 minutes, 2 hours, 3 day, 4 weekday, 5 month and 6 year. A write stores the data, masked to the field's width, at the next rising edge. If a write falls in a tick cycle, no field advances for that tick, so the write never causes a carry.
- R10: `rd_data_o` shows the addressed field combinationally, with bits above the field width reading zero: 7 bits for seconds and minutes, 6 for hours and day, 3 for weekday, 5 for month and 8 for year. Address 7 reads zero, and writes to it are ignored.
- R11: A synchronous reset sets 00:00:00, day 01, weekday 0, month 01 and year 00, and clears the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_i | input | 1 | Freeze fields and hold prescaler at zero |
| mode_12h_i | input | 1 | 1 selects 12-hour hour encoding |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 3 | Write field address |
| wr_data_i | input | 8 | Write data (BCD) |
| rd_addr_i | input | 3 | Read field address |
| rd_data_o | output | 8 | Addressed field, zero-extended |
| tick_1hz_o | output | 1 | One-cycle pulse per second |
| div_4096_o | output | 1 | Prescaler tap, nominally 4096 Hz |
| div_64_o | output | 1 | Prescaler tap, nominally 64 Hz |
| div_1hz_o | output | 1 | Prescaler tap, nominally 1 Hz |

## Verification
The bench uses a 2-bit prescaler and a reference model built from plain integers. It walks every day from the start of a non-leap year through the next leap year, across the 99-to-00 year wrap, so a wrong month length or leap test shows up as a skipped or extra day. It steps through every hour in both hour encodings, which exposes a missing afternoon toggle or a day carry at noon instead of at midnight. It counts the exact edge of the first advance after stop is released, so a prescaler that is frozen rather than cleared is caught. It also places a write exactly in a tick cycle: a design that lets the write race the carry would show a wrong seconds value or a stray minute increment.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
// Shared field addresses and BCD helpers for the calendar counter.
// Assumes all field values are two-digit packed BCD in eight bits.
package rtc_pkg;
    typedef enum logic [2:0] {
        F_SEC  = 3'd0,
        F_MIN  = 3'd1,
        F_HOUR = 3'd2,
        F_DAY  = 3'd3,
        F_WDAY = 3'd4,
        F_MON  = 3'd5,
        F_YEAR = 3'd6,
        F_NONE = 3'd7
    } field_e;

    // One BCD increment: returns {wrapped, next}; values at or above top wrap to bottom.
    function automatic logic [8:0] bcd_step(input logic [7:0] v,
                                            input logic [7:0] top,
                                            input logic [7:0] bottom);
        if (v >= top)
            return {1'b1, bottom};
        else if (v[3:0] >= 4'd9)
            return {1'b0, v[7:4] + 4'd1, 4'd0};
        else
            return {1'b0, v[7:4], v[3:0] + 4'd1};
    endfunction

    // Binary value of a two-digit BCD number.
    function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction

    // Last valid day (BCD) of a month (BCD), taking leap years into account.
    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return ((bcd_to_bin(yr) % 7'd4) == 7'd0) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
// Binary divider from the reference clock to the once-per-second tick.
// Assumes clk is the reference clock; PRE_W = 15 gives 1 Hz from 32.768 kHz.
// Stop clears the count so the next second starts from a known phase.
module rtc_prescaler #(
    parameter int PRE_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_i,
    output logic tick_o,
    output logic div_4096_o,
    output logic div_64_o,
    output logic div_1hz_o
);
    localparam int TAP_1   = PRE_W - 1;
    localparam int TAP_4K  = (PRE_W > 2) ? 2 : TAP_1;
    localparam int TAP_64  = (PRE_W > 8) ? 8 : TAP_1;

    logic [PRE_W-1:0] cnt;

    // Count reference cycles; held at zero by reset or stop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (stop_i)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // Tick in the last cycle of each period; taps are plain count bits.
    always_comb begin
        tick_o     = !stop_i && (&cnt);
        div_4096_o = cnt[TAP_4K];
        div_64_o   = cnt[TAP_64];
        div_1hz_o  = cnt[TAP_1];
    end

    a_r2_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (cnt == '0));
    a_r1_tick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (cnt == '0));
    a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/rtc_time_chain.sv
`timescale 1ns/1ps
// Seconds, minutes and hours counters with their carry cascade.
// Assumes adv_i is already suppressed in write cycles by the parent.
// The hour field follows mode_12h_i: bit 5 is the afternoon flag in 12-hour mode.
module rtc_time_chain
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv_i,
    input  logic       mode_12h_i,
    input  logic       wr_en_i,
    input  logic [2:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic       day_adv_o
);
    logic [8:0] sec_nx, min_nx, hr_step;
    logic [7:0] hour_next;
    logic       hour_wrap;

    // Next-value logic for seconds and minutes.
    always_comb begin
        sec_nx = bcd_step(sec_o, 8'h59, 8'h00);
        min_nx = bcd_step(min_o, 8'h59, 8'h00);
    end

    // Next hour in the selected encoding, plus the carry into the day.
    always_comb begin
        hour_next = hour_o;
        hour_wrap = 1'b0;
        if (mode_12h_i) begin
            hr_step = bcd_step({3'b0, hour_o[4:0]}, 8'h12, 8'h01);
            if (hour_o[4:0] == 5'h11) begin
                hour_next = {2'b0, ~hour_o[5], 5'h12};
                hour_wrap = hour_o[5];
            end else if (hour_o[4:0] == 5'h00) begin
                hour_next = {2'b0, hour_o[5], 5'h01};
            end else begin
                hour_next = {2'b0, hour_o[5], hr_step[4:0]};
            end
        end else begin
            hr_step   = bcd_step(hour_o, 8'h23, 8'h00);
            hour_next = hr_step[7:0];
            hour_wrap = hr_step[8];
        end
    end

    assign day_adv_o = adv_i && sec_nx[8] && min_nx[8] && hour_wrap;

    // Field registers: a host write wins; otherwise advance on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_o  <= 8'h00;
            min_o  <= 8'h00;
            hour_o <= 8'h00;
        end else if (wr_en_i) begin
            case (field_e'(wr_addr_i))
                F_SEC:   sec_o  <= {1'b0, wr_data_i[6:0]};
                F_MIN:   min_o  <= {1'b0, wr_data_i[6:0]};
                F_HOUR:  hour_o <= {2'b0, wr_data_i[5:0]};
                default: ;
            endcase
        end else if (adv_i) begin
            sec_o <= sec_nx[7:0];
            if (sec_nx[8]) begin
                min_o <= min_nx[7:0];
                if (min_nx[8])
                    hour_o <= hour_next;
            end
        end
    end

    a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i && !wr_en_i && sec_o == 8'h59 |=> sec_o == 8'h00);
    a_r9_write_sec: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && wr_addr_i == 3'd0 |=> sec_o == {1'b0, $past(wr_data_i[6:0])});
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i && !wr_en_i |=> $stable(sec_o) && $stable(min_o) && $stable(hour_o));
    a_r5_pm_flip: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i && !wr_en_i && mode_12h_i && sec_o == 8'h59 && min_o == 8'h59 && hour_o[4:0] == 5'h11
        |=> hour_o[5] != $past(hour_o[5]) && hour_o[4:0] == 5'h12);
endmodule

// File: rtl/rtc_date_chain.sv
`timescale 1ns/1ps
// Day, weekday, month and year counters driven by the day carry.
// Assumes day_adv_i is low in write cycles; month length comes from the package.
module rtc_date_chain
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       day_adv_i,
    input  logic       wr_en_i,
    input  logic [2:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] day_o,
    output logic [2:0] wday_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o
);
    logic [7:0] last_day;
    logic [8:0] day_nx, mon_nx, yr_nx;
    logic [2:0] wday_nx;

    // Next-value logic for every date field.
    always_comb begin
        last_day = month_last(month_o, year_o);
        day_nx   = bcd_step(day_o, last_day, 8'h01);
        mon_nx   = bcd_step(month_o, 8'h12, 8'h01);
        yr_nx    = bcd_step(year_o, 8'h99, 8'h00);
        wday_nx  = (wday_o >= 3'd6) ? 3'd0 : wday_o + 3'd1;
    end

    // Field registers: a host write wins; otherwise advance on the day carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            day_o   <= 8'h01;
            wday_o  <= 3'd0;
            month_o <= 8'h01;
            year_o  <= 8'h00;
        end else if (wr_en_i) begin
            case (field_e'(wr_addr_i))
                F_DAY:   day_o   <= {2'b0, wr_data_i[5:0]};
                F_WDAY:  wday_o  <= wr_data_i[2:0];
                F_MON:   month_o <= {3'b0, wr_data_i[4:0]};
                F_YEAR:  year_o  <= wr_data_i;
                default: ;
            endcase
        end else if (day_adv_i) begin
            wday_o <= wday_nx;
            day_o  <= day_nx[7:0];
            if (day_nx[8]) begin
                month_o <= mon_nx[7:0];
                if (mon_nx[8])
                    year_o <= yr_nx[7:0];
            end
        end
    end

    a_r7_week_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        day_adv_i && !wr_en_i && wday_o == 3'd6 |=> wday_o == 3'd0);
    a_r6_month_end: assert property (@(posedge clk) disable iff (!rst_n)
        day_adv_i && !wr_en_i && day_o == last_day |=> day_o == 8'h01);
    a_r6_leap_feb: assert property (@(posedge clk) disable iff (!rst_n)
        day_adv_i && !wr_en_i && month_o == 8'h02 && day_o == 8'h28 && year_o == 8'h24
        |=> day_o == 8'h29);
    a_r8_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        day_adv_i && !wr_en_i && day_o == last_day && month_o == 8'h12 && year_o == 8'h99
        |=> year_o == 8'h00);
endmodule

// File: rtl/rtc_bcd_calendar.sv
`timescale 1ns/1ps
// Top of the BCD time and calendar counter: prescaler, time chain, date chain
// and the combinational read mux. A write cycle swallows a coincident tick.
module rtc_bcd_calendar
    import rtc_pkg::*;
#(
    parameter int PRE_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_i,
    input  logic       mode_12h_i,
    input  logic       wr_en_i,
    input  logic [2:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic [2:0] rd_addr_i,
    output logic [7:0] rd_data_o,
    output logic       tick_1hz_o,
    output logic       div_4096_o,
    output logic       div_64_o,
    output logic       div_1hz_o
);
    logic       tick, adv, day_adv;
    logic [7:0] sec, min, hour, day, month, year;
    logic [2:0] wday;

    rtc_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .tick_o(tick),
        .div_4096_o(div_4096_o), .div_64_o(div_64_o), .div_1hz_o(div_1hz_o)
    );

    // A write in a tick cycle cancels that second's advance.
    assign adv        = tick && !wr_en_i;
    assign tick_1hz_o = tick;

    rtc_time_chain u_time (
        .clk(clk), .rst_n(rst_n), .adv_i(adv), .mode_12h_i(mode_12h_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .sec_o(sec), .min_o(min), .hour_o(hour), .day_adv_o(day_adv)
    );

    rtc_date_chain u_date (
        .clk(clk), .rst_n(rst_n), .day_adv_i(day_adv),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .day_o(day), .wday_o(wday), .month_o(month), .year_o(year)
    );

    // Read mux: addressed field, zero-extended; unused address reads zero.
    always_comb begin
        case (field_e'(rd_addr_i))
            F_SEC:   rd_data_o = sec;
            F_MIN:   rd_data_o = min;
            F_HOUR:  rd_data_o = hour;
            F_DAY:   rd_data_o = day;
            F_WDAY:  rd_data_o = {5'b0, wday};
            F_MON:   rd_data_o = month;
            F_YEAR:  rd_data_o = year;
            default: rd_data_o = 8'h00;
        endcase
    end

    a_r2_stop_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i && !wr_en_i |=> $stable(sec) && $stable(day) && $stable(year));
    a_r9_tick_swallowed: assert property (@(posedge clk) disable iff (!rst_n)
        tick && wr_en_i && wr_addr_i != 3'd0 |=> $stable(sec));
endmodule

// File: tb/rtc_bcd_calendar_tb.sv
`timescale 1ns/1ps
// Self-checking bench: 2-bit prescaler, integer reference model, calendar sweep.
module rtc_bcd_calendar_tb;
    localparam int PW = 2;
    localparam int PERIOD = 1 << PW;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop = 1'b1;
    logic       mode12 = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic       tick, d4k, d64, d1;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    rtc_bcd_calendar #(.PRE_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .stop_i(stop), .mode_12h_i(mode12),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .tick_1hz_o(tick),
        .div_4096_o(d4k), .div_64_o(d64), .div_1hz_o(d1)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int dim(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] enc12(input int h24);
        int hh;
        hh = h24 % 12;
        if (hh == 0) hh = 12;
        return (h24 >= 12 ? 8'h20 : 8'h00) | bcd(hh);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        peek(a, v);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        wr(3'd2, h); wr(3'd1, m); wr(3'd0, s);
    endtask

    // Release stop for exactly one prescaler period, then freeze again.
    task automatic one_sec();
        @(negedge clk);
        stop = 1'b0;
        repeat (PERIOD) @(posedge clk);
        @(negedge clk);
        stop = 1'b1;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, s0;
        int d, mo, y, wd, h, dayc, tk, rises, mism;
        logic prev;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11 reset values, R10 unused address
        rd(3'd0, v); chk("R11 sec", v, 8'h00);
        rd(3'd1, v); chk("R11 min", v, 8'h00);
        rd(3'd2, v); chk("R11 hour", v, 8'h00);
        rd(3'd3, v); chk("R11 day", v, 8'h01);
        rd(3'd4, v); chk("R11 wday", v, 8'h00);
        rd(3'd5, v); chk("R11 month", v, 8'h01);
        rd(3'd6, v); chk("R11 year", v, 8'h00);
        rd(3'd7, v); chk("R10 addr7", v, 8'h00);

        // R3 seconds sweep, then minute wrap for every minute value
        load_time(8'h05, 8'h00, 8'h00);
        for (int s = 1; s <= 60; s++) begin
            one_sec();
            peek(3'd0, v); chk("R3 sec", v, bcd(s % 60));
            peek(3'd1, v); chk("R3 min carry", v, (s == 60) ? 8'h01 : 8'h00);
        end
        for (int m = 0; m < 60; m++) begin
            load_time(8'h05, bcd(m), 8'h59);
            one_sec();
            peek(3'd1, v); chk("R3 min", v, bcd((m + 1) % 60));
            peek(3'd2, v); chk("R3 hour carry", v, (m == 59) ? 8'h06 : 8'h05);
        end

        // R4 24-hour sweep with day carry
        wr(3'd3, 8'h10); wr(3'd5, 8'h03); wr(3'd6, 8'h21);
        dayc = 10;
        for (int hh = 0; hh < 24; hh++) begin
            load_time(bcd(hh), 8'h59, 8'h59);
            one_sec();
            if (hh == 23) dayc++;
            peek(3'd2, v); chk("R4 hour", v, bcd((hh + 1) % 24));
            peek(3'd3, v); chk("R4 day carry", v, bcd(dayc));
        end

        // R5 12-hour sweep with afternoon flag and day carry
        mode12 = 1'b1;
        for (int hh = 0; hh < 24; hh++) begin
            load_time(enc12(hh), 8'h59, 8'h59);
            one_sec();
            if (hh == 23) dayc++;
            peek(3'd2, v); chk("R5 hour12", v, enc12((hh + 1) % 24));
            peek(3'd3, v); chk("R5 day carry", v, bcd(dayc));
        end
        mode12 = 1'b0;

        // R6 R7 R8 calendar sweep across four years incl. leap year 00 and 99->00
        d = 1; mo = 1; y = 97; wd = 5;
        wr(3'd3, bcd(d)); wr(3'd4, bcd(wd)); wr(3'd5, bcd(mo)); wr(3'd6, bcd(y));
        for (int i = 0; i < 1461; i++) begin
            load_time(8'h23, 8'h59, 8'h59);
            one_sec();
            wd = (wd + 1) % 7;
            d++;
            if (d > dim(mo, y)) begin
                d = 1; mo++;
                if (mo > 12) begin mo = 1; y = (y + 1) % 100; end
            end
            peek(3'd3, v); chk("R6 day", v, bcd(d));
            peek(3'd5, v); chk("R8 month", v, bcd(mo));
            peek(3'd6, v); chk("R8 year", v, bcd(y));
            peek(3'd4, v); chk("R7 wday", v, bcd(wd));
        end

        // R9 R10 masking, R7 out-of-range weekday
        wr(3'd0, 8'hFF); rd(3'd0, v); chk("R10 sec mask", v, 8'h7F);
        wr(3'd4, 8'hFF); rd(3'd4, v); chk("R9 wday mask", v, 8'h07);
        wr(3'd7, 8'h55); rd(3'd7, v); chk("R10 addr7 write", v, 8'h00);
        load_time(8'h23, 8'h59, 8'h59);
        one_sec();
        peek(3'd4, v); chk("R7 wday 7 wraps", v, 8'h00);

        // R2 stop holds everything; first advance on the PERIOD-th edge
        load_time(8'h08, 8'h30, 8'h10);
        mism = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (tick || d1 || d64 || d4k) mism++;
        end
        chk("R2 outputs low in stop", 8'(mism), 8'h00);
        peek(3'd0, v); chk("R2 sec frozen", v, 8'h10);
        @(negedge clk);
        stop = 1'b0;
        peek(3'd0, s0);
        for (int e = 1; e <= PERIOD; e++) begin
            @(posedge clk);
            @(negedge clk);
            peek(3'd0, v);
            chk("R2 first advance", v, (e < PERIOD) ? s0 : 8'h11);
            if (e == PERIOD - 1) chk("R1 tick cycle", 8'(tick), 8'h01);
            if (e < PERIOD - 1) chk("R1 no early tick", 8'(tick), 8'h00);
        end
        stop = 1'b1;

        // R1 tick rate and 1 Hz tap period over 10 periods
        @(negedge clk);
        stop = 1'b0;
        tk = 0; rises = 0; mism = 0; prev = d1;
        for (int k = 1; k <= 10 * PERIOD; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (tick) tk++;
            if (d1 && !prev) rises++;
            prev = d1;
            if (d1 !== (((k % PERIOD) >> (PW - 1)) & 1)) mism++;
        end
        stop = 1'b1;
        chk("R1 tick count", 8'(tk), 8'd10);
        chk("R1 tap rises", 8'(rises), 8'd10);
        chk("R1 tap phase", 8'(mism), 8'd0);

        // R9 write in a tick cycle: no advance, no carry
        load_time(8'h10, 8'h59, 8'h59);
        @(negedge clk);
        stop = 1'b0;
        repeat (PERIOD - 1) @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h20;
        @(negedge clk);
        wr_en = 1'b0; stop = 1'b1;
        peek(3'd0, v); chk("R9 collide sec", v, 8'h59);
        peek(3'd1, v); chk("R9 collide min", v, 8'h20);
        peek(3'd2, v); chk("R9 collide hour", v, 8'h10);
        one_sec();
        peek(3'd0, v); chk("R9 after sec", v, 8'h00);
        peek(3'd1, v); chk("R9 after min", v, 8'h21);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule